// File: doc/BRIEF.md
# Single-Channel Palette Access Controller

This block is the processor-side access logic for one colour channel of a 256-entry, 8-bit colour lookup table. A host reaches it through an 8-bit data bus with an active-low chip enable, single-cycle read and write strobes and a 2-bit register select. Through that bus the host can load the palette address, transfer palette bytes and use a 4-bit control/test register. The palette entry chosen by the pixel index is registered every clock and drives the DAC-data output.

The control/test register sets how palette transfers behave. When its three colour enable bits are all clear, every palette access moves one byte for this channel. When exactly one enable bit is set, the channel assumes the host runs repeating red, green, blue triplets, as it would on a three-colour device sharing one 8-bit bus. The channel then takes part only in the slot of its own colour. A read of the control/test register returns the stored bits together with one nibble of the byte now being fed to the DAC, which lets the host inspect the live pixel path.

Top module: `palette_chan_ctrl`

## Requirements
- R1: A control/test write (regSel=2) stores dataIn[3:0] and discards dataIn[7:4]. A later control/test read returns the stored bits on dataOut[3:0]. The register has no reset value.
- R2: On a control/test read, dataOut[7:4] holds a nibble of the current dacData. It is the low nibble when stored bit 3 is 1 and the high nibble when stored bit 3 is 0.
- R3: With enable bits [2:0] all 0, a palette write (regSel=1) stores the whole byte at the current address, and the address then increments by one, wrapping from 255 to 0.
- R4: With enable bits [2:0] all 0, a palette read drives the entry at the current address with dataOe high, and the address then increments by one.
- R5: With one enable bit set (bit 0 red, bit 1 green, bit 2 blue), palette writes run through the slots red, green, blue in that order. Only the write in the enabled colour's slot changes the entry, and the address increments after each blue-slot access.
- R6: With one enable bit set, a palette read drives data with dataOe high only in the enabled colour's slot. In the other two slots dataOe is low.
- R7: A write to the address register (regSel=0) loads the address and returns the slot sequence to red. Each chip-enabled palette access advances the slot by one, modulo 3.
- R8: dataOe is high only during a chip-enabled read of the address register, the control/test register, or a responding palette slot. It is low on writes and on regSel=3. dataOut is 0 whenever dataOe is low.
- R9: dacData equals the palette entry at pixelIdx as sampled on the previous rising clock edge.
- R10: A strobe with csN high changes no register, entry, address or slot, and leaves dataOe low.
- R11: A read of the address register returns the current palette address. Reset clears the address, the slot and dacData.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel and bus clock |
| rst_n | input | 1 | Active-low reset for address, slot and DAC register |
| csN | input | 1 | Active-low chip enable |
| rdStb | input | 1 | Read strobe, one cycle per access |
| wrStb | input | 1 | Write strobe, one cycle per access |
| regSel | input | 2 | 0 address, 1 palette, 2 control/test, 3 reserved |
| dataIn | input | 8 | Write data from host |
| dataOut | output | 8 | Read data to host |
| dataOe | output | 1 | Bus drive enable for dataOut |
| pixelIdx | input | 8 | Palette index of the current pixel |
| dacData | output | 8 | Registered palette byte for the DAC |

## Verification
The bench goes after the slot sequence in each of the three single-enable modes. A controller whose slot counter was off by one would store the neighbouring colour's byte or drive the bus in the wrong slot. The bench also reloads the address partway through a triplet; a counter that did not resync would leave the next red access ignored. It aims at the address wrap at 255 and checks that the discarded upper nibble of a control write never shows up in the stored bits. It also checks which nibble the test readback selects, so a design with the nibble polarity swapped would return the wrong half of the DAC byte.

// File: rtl/palette_chan_pkg.sv
package palette_chan_pkg;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_PAL  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_RSVD = 2'd3
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic addrWr;
    logic addrInc;
    logic palWr;
    logic rdAddr;
    logic rdPal;
    logic rdCtrl;
  } accStb_t;

endpackage

// File: rtl/palette_chan_ctl.sv
module palette_chan_ctl
  import palette_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       csN,
  input  logic       rdStb,
  input  logic       wrStb,
  input  logic [1:0] regSel,
  input  logic [3:0] ctrlWrData,
  output logic [3:0] ctrlReg,
  output accStb_t    stb
);

  localparam logic [1:0] SLOT_RED  = 2'd0;
  localparam logic [1:0] SLOT_BLUE = 2'd2;

  regSel_e    sel;
  logic       access;
  logic       palAcc;
  logic       emuMode;
  logic       slotHit;
  logic [1:0] slot;
  logic [2:0] colourEn;

  assign sel      = regSel_e'(regSel);
  assign access   = !csN && (rdStb || wrStb);
  assign palAcc   = access && (sel == SEL_PAL);
  assign colourEn = ctrlReg[2:0];
  assign emuMode  = |colourEn;

  always_comb begin
    case (slot)
      2'd0:    slotHit = colourEn[0];
      2'd1:    slotHit = colourEn[1];
      default: slotHit = colourEn[2];
    endcase
  end

  always_comb begin
    stb         = '0;
    stb.addrWr  = access && wrStb && (sel == SEL_ADDR);
    stb.palWr   = palAcc && wrStb && (!emuMode || slotHit);
    stb.addrInc = palAcc && (!emuMode || slot == SLOT_BLUE);
    stb.rdAddr  = access && rdStb && (sel == SEL_ADDR);
    stb.rdPal   = palAcc && rdStb && (!emuMode || slotHit);
    stb.rdCtrl  = access && rdStb && (sel == SEL_CTRL);
  end

  // control/test register: deliberately without reset
  always_ff @(posedge clk) begin
    if (access && wrStb && sel == SEL_CTRL) ctrlReg <= ctrlWrData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          slot <= SLOT_RED;
    else if (stb.addrWr) slot <= SLOT_RED;
    else if (palAcc)     slot <= (slot == SLOT_BLUE) ? SLOT_RED : slot + 2'd1;
  end

endmodule

// File: rtl/palette_chan_dp.sv
module palette_chan_dp
  import palette_chan_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  accStb_t           stb,
  input  logic              lowNibSel,
  input  logic [3:0]        ctrlBits,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [ADDR_W-1:0] pixelIdx,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic [DATA_W-1:0] dacData
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int NIB_W = DATA_W / 2;

  logic [DATA_W-1:0] palMem [DEPTH];
  logic [ADDR_W-1:0] palAddr;
  logic [NIB_W-1:0]  testNib;

  always_ff @(posedge clk) begin
    if (stb.palWr) palMem[palAddr] <= dataIn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           palAddr <= '0;
    else if (stb.addrWr)  palAddr <= dataIn[ADDR_W-1:0];
    else if (stb.addrInc) palAddr <= palAddr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dacData <= '0;
    else        dacData <= palMem[pixelIdx];
  end

  assign testNib = lowNibSel ? dacData[NIB_W-1:0] : dacData[DATA_W-1:NIB_W];
  assign dataOe  = stb.rdAddr || stb.rdPal || stb.rdCtrl;

  always_comb begin
    dataOut = '0;
    if (stb.rdAddr)      dataOut = DATA_W'(palAddr);
    else if (stb.rdPal)  dataOut = palMem[palAddr];
    else if (stb.rdCtrl) dataOut = {testNib, (NIB_W)'(ctrlBits)};
  end

endmodule

// File: rtl/palette_chan_ctrl.sv
module palette_chan_ctrl
  import palette_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       csN,
  input  logic       rdStb,
  input  logic       wrStb,
  input  logic [1:0] regSel,
  input  logic [7:0] dataIn,
  output logic [7:0] dataOut,
  output logic       dataOe,
  input  logic [7:0] pixelIdx,
  output logic [7:0] dacData
);

  accStb_t    stb;
  logic [3:0] ctrlReg;

  palette_chan_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .csN        (csN),
    .rdStb      (rdStb),
    .wrStb      (wrStb),
    .regSel     (regSel),
    .ctrlWrData (dataIn[3:0]),
    .ctrlReg    (ctrlReg),
    .stb        (stb)
  );

  palette_chan_dp #(.DATA_W(8), .ADDR_W(8)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .lowNibSel (ctrlReg[3]),
    .ctrlBits  (ctrlReg),
    .dataIn    (dataIn),
    .pixelIdx  (pixelIdx),
    .dataOut   (dataOut),
    .dataOe    (dataOe),
    .dacData   (dacData)
  );

endmodule

// File: rtl/palette_chan_ctrl_chk.sv
module palette_chan_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       csN,
  input logic       rdStb,
  input logic       wrStb,
  input logic [1:0] regSel,
  input logic [3:0] dataInLo,
  input logic [7:0] dataOut,
  input logic       dataOe,
  input logic [7:0] dacData
);

  logic [3:0] shadowCtrl;
  logic       shadowValid;
  logic       ctrlRead;

  assign ctrlRead = !csN && rdStb && !wrStb && regSel == 2'd2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadowCtrl  <= '0;
      shadowValid <= 1'b0;
    end else if (!csN && wrStb && !rdStb && regSel == 2'd2) begin
      shadowCtrl  <= dataInLo;
      shadowValid <= 1'b1;
    end
  end

  AST_OE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    dataOe |-> (!csN && rdStb)); // R8

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    csN |-> !dataOe); // R10

  AST_CTRL_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    (shadowValid && ctrlRead) |-> (dataOe && dataOut[3:0] == shadowCtrl)); // R1

  AST_TEST_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (shadowValid && ctrlRead) |->
      (dataOut[7:4] == (shadowCtrl[3] ? dacData[3:0] : dacData[7:4]))); // R2

endmodule

bind palette_chan_ctrl palette_chan_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .csN      (csN),
  .rdStb    (rdStb),
  .wrStb    (wrStb),
  .regSel   (regSel),
  .dataInLo (dataIn[3:0]),
  .dataOut  (dataOut),
  .dataOe   (dataOe),
  .dacData  (dacData)
);

// File: tb/tb_palette_chan_ctrl.sv
module tb_palette_chan_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       csN = 1'b1;
  logic       rdStb = 1'b0;
  logic       wrStb = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic [7:0] dataIn = 8'd0;
  logic [7:0] dataOut;
  logic       dataOe;
  logic [7:0] pixelIdx = 8'd0;
  logic [7:0] dacData;

  int checks = 0;
  int failures = 0;

  // bench model
  logic [7:0] mMem [256];
  logic [7:0] mAddr = 8'd0;
  logic [1:0] mSlot = 2'd0;
  logic [3:0] mCtrl = 4'd0;
  logic [7:0] mPix = 8'd0;

  always #4 clk = ~clk;

  palette_chan_ctrl dut (
    .clk(clk), .rst_n(rst_n), .csN(csN), .rdStb(rdStb), .wrStb(wrStb),
    .regSel(regSel), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .pixelIdx(pixelIdx), .dacData(dacData)
  );

  task automatic chk(input bit ok, input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit mHit();
    if (mCtrl[2:0] == 3'b000) return 1'b1;
    case (mSlot)
      2'd0:    return mCtrl[0];
      2'd1:    return mCtrl[1];
      default: return mCtrl[2];
    endcase
  endfunction

  function automatic logic [8:0] mRead(input logic [1:0] sel);
    logic [7:0] dac;
    dac = mMem[mPix];
    case (sel)
      2'd0:    return {1'b1, mAddr};
      2'd1:    return mHit() ? {1'b1, mMem[mAddr]} : 9'd0;
      2'd2:    return {1'b1, (mCtrl[3] ? dac[3:0] : dac[7:4]), mCtrl};
      default: return 9'd0;
    endcase
  endfunction

  task automatic mUpdate(input bit isWr, input logic [1:0] sel, input logic [7:0] d);
    bit emu;
    emu = (mCtrl[2:0] != 3'b000);
    case (sel)
      2'd0: if (isWr) begin mAddr = d; mSlot = 2'd0; end
      2'd1: begin
        if (isWr && mHit()) mMem[mAddr] = d;
        if (!emu || mSlot == 2'd2) mAddr = mAddr + 8'd1;
        mSlot = (mSlot == 2'd2) ? 2'd0 : mSlot + 2'd1;
      end
      2'd2: if (isWr) mCtrl = d[3:0];
      default: ;
    endcase
  endtask

  // one access cycle followed by one idle cycle
  task automatic doOp(input bit isWr, input logic [1:0] sel, input logic [7:0] d,
                      input bit cs, input string req);
    logic [8:0] exp;
    @(negedge clk);
    csN = !cs; rdStb = !isWr; wrStb = isWr; regSel = sel; dataIn = d;
    #2;
    if (!cs || isWr) exp = 9'd0;
    else exp = mRead(sel);
    chk({dataOe, dataOut} == exp, req, {dataOe, dataOut}, exp);
    @(posedge clk);
    #1;
    if (cs) mUpdate(isWr, sel, d);
    csN = 1'b1; rdStb = 1'b0; wrStb = 1'b0;
    @(posedge clk);
  endtask

  task automatic setPix(input logic [7:0] p);
    @(negedge clk);
    pixelIdx = p; mPix = p;
    @(posedge clk);
    @(negedge clk);
    chk(dacData == mMem[p], "R9", {1'b0, dacData}, {1'b0, mMem[p]});
  endtask

  initial begin
    logic [7:0] base;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dataOe == 1'b0 && dacData == 8'd0, "R11", {dataOe, dacData}, 9'd0);
    rst_n = 1'b1;
    doOp(1'b0, 2'd0, 8'd0, 1'b1, "R11");             // address reads 0 after reset
    doOp(1'b1, 2'd2, 8'hA0, 1'b1, "R1");             // upper nibble discarded
    // fill the palette in direct mode, crossing the 255->0 wrap
    doOp(1'b1, 2'd0, 8'd0, 1'b1, "R7");
    for (int i = 0; i < 256; i++) doOp(1'b1, 2'd1, 8'($urandom), 1'b1, "R3");
    doOp(1'b0, 2'd0, 8'd0, 1'b1, "R3");              // wrapped to 0
    doOp(1'b0, 2'd2, 8'd0, 1'b1, "R1");
    // direct reads across the wrap
    doOp(1'b1, 2'd0, 8'd253, 1'b1, "R11");
    for (int i = 0; i < 5; i++) doOp(1'b0, 2'd1, 8'd0, 1'b1, "R4");
    doOp(1'b0, 2'd0, 8'd0, 1'b1, "R4");
    // DAC path and test nibble, both polarities
    setPix(8'd77);
    doOp(1'b1, 2'd2, 8'hF8, 1'b1, "R1");
    doOp(1'b0, 2'd2, 8'd0, 1'b1, "R2");
    doOp(1'b1, 2'd2, 8'h50, 1'b1, "R1");
    doOp(1'b0, 2'd2, 8'd0, 1'b1, "R2");
    doOp(1'b1, 2'd0, 8'd77, 1'b1, "R11");
    doOp(1'b1, 2'd1, 8'h3C, 1'b1, "R3");
    setPix(8'd77);
    doOp(1'b0, 2'd2, 8'd0, 1'b1, "R2");
    // deselected strobes
    doOp(1'b1, 2'd0, 8'd9, 1'b1, "R11");
    doOp(1'b1, 2'd1, 8'h11, 1'b0, "R10");
    doOp(1'b1, 2'd0, 8'd55, 1'b0, "R10");
    doOp(1'b1, 2'd2, 8'h01, 1'b0, "R10");
    doOp(1'b0, 2'd1, 8'd0, 1'b0, "R10");
    doOp(1'b0, 2'd0, 8'd0, 1'b1, "R10");
    doOp(1'b0, 2'd1, 8'd0, 1'b1, "R10");
    doOp(1'b0, 2'd3, 8'd0, 1'b1, "R8");
    // emulated triplets for each colour
    for (int c = 0; c < 3; c++) begin
      base = 8'(40 + 4 * c);
      doOp(1'b1, 2'd2, 8'(1 << c), 1'b1, "R1");
      doOp(1'b1, 2'd0, base, 1'b1, "R7");
      for (int k = 0; k < 6; k++) doOp(1'b1, 2'd1, 8'($urandom), 1'b1, "R5");
      doOp(1'b0, 2'd0, 8'd0, 1'b1, "R5");          // advanced by two
      doOp(1'b1, 2'd0, base, 1'b1, "R7");
      for (int k = 0; k < 6; k++) doOp(1'b0, 2'd1, 8'd0, 1'b1, "R6");
      doOp(1'b1, 2'd2, 8'd0, 1'b1, "R1");
      doOp(1'b1, 2'd0, base - 8'd1, 1'b1, "R5");
      for (int k = 0; k < 4; k++) doOp(1'b0, 2'd1, 8'd0, 1'b1, "R5");
    end
    // address reload mid-triplet returns to red
    doOp(1'b1, 2'd2, 8'h01, 1'b1, "R1");
    doOp(1'b1, 2'd0, 8'd90, 1'b1, "R7");
    doOp(1'b1, 2'd1, 8'hAA, 1'b1, "R7");
    doOp(1'b1, 2'd0, 8'd90, 1'b1, "R7");
    doOp(1'b1, 2'd1, 8'h5B, 1'b1, "R7");
    doOp(1'b0, 2'd0, 8'd0, 1'b1, "R7");
    doOp(1'b1, 2'd0, 8'd90, 1'b1, "R7");
    doOp(1'b0, 2'd1, 8'd0, 1'b1, "R7");
    // constrained random mix
    for (int n = 0; n < 500; n++) begin
      int r;
      logic [1:0] sel;
      bit isWr;
      r = int'($urandom_range(0, 99));
      if (r < 6) begin
        logic [2:0] en;
        case ($urandom_range(0, 3))
          0: en = 3'b000;
          1: en = 3'b001;
          2: en = 3'b010;
          default: en = 3'b100;
        endcase
        doOp(1'b1, 2'd2, {4'($urandom), 1'($urandom), en}, 1'b1, "R1");
      end else if (r < 9) begin
        setPix(8'($urandom));
      end else begin
        sel = (r < 70) ? 2'd1 : 2'($urandom);
        if (sel == 2'd2) isWr = 1'b0;
        else isWr = (r % 2 == 0);
        doOp(isWr, sel, 8'($urandom), (r % 13 != 0),
             (sel == 2'd1) ? ((mCtrl[2:0] == 3'b000) ? "R4" : "R6") :
             (sel == 2'd0) ? "R11" : (sel == 2'd2) ? "R2" : "R8");
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule